// File: doc/BRIEF.md
# Oversampling Manchester Data Recovery Receiver

This block turns a Manchester-coded serial line into NRZ data and a per-bit strobe, with no recovered clock. The line is sampled on both edges of a sampling clock, outside this block. Each cycle the block receives the two resulting samples, earlier sample first. With the default of 8 samples per bit (four per half-bit), one bit lasts four cycles.

A sample-tick phase counter predicts where each mid-bit transition should fall. The counter is re-aligned to every accepted mid-bit transition. The block emits a strobe only in the cycle where a mid-bit transition is taken, and the bit value is latched only on that strobe. Transitions at bit boundaries carry no data and are skipped.

A three-state controller governs acquisition:
- **HUNT**: waits for any transition.
- **TRAIN**: counts consecutive well-placed bits.
- **LOCK**: the lock flag is raised.

The transitions between states are:
- HUNT to TRAIN on the first transition seen.
- TRAIN to LOCK when the 16th consecutive bit is accepted.
- TRAIN to HUNT on one missing mid-bit transition.
- LOCK to HUNT on the 4th consecutive missing mid-bit transition.
- Any state to HUNT on reset.
- While the enable is low, every state holds.

Top module: `manch_cdr_rx`

## Requirements
- R1: On a clock edge with `rst` high, `rx_stb` and `locked` go low, and the tracker returns to HUNT with its phase counter at zero.
- R2: Each accepted mid-bit transition gives exactly one single-cycle `rx_stb` pulse, plus `rx_bit` = 1 for low-to-high or 0 for high-to-low. The pulse appears on the clock edge that takes the sample pair holding the first sample at the new level, where `smp_early` is the earlier sample of the pair.
- R3: In TRAIN and LOCK, a transition more than one sample away from the expected mid-bit position (a bit-boundary transition) produces no strobe.
- R4: A mid-bit transition one sample early or late against the expected position is accepted, and the phase is re-aligned to it. A stream whose mid-bit spacing varies by one sample from bit to bit stays decoded and locked.
- R5: `locked` rises on the same edge as the strobe of the 16th consecutive accepted bit, counting the bit that left HUNT as the first.
- R6: In TRAIN, a bit period with no mid-bit transition returns the tracker to HUNT and restarts the bit count.
- R7: In LOCK, up to 3 consecutive bit periods without a mid-bit transition keep `locked` high and give no strobe, and an accepted transition clears the miss count.
- R8: On the 4th consecutive missing transition, `locked` falls on the edge that takes sample number 4*SPB+1 counted after the last accepted transition sample.
- R9: With `en` low in a cycle, that cycle's samples are discarded, `rx_stb` is low after the edge, and `locked` and all tracker state hold.
- R10: In HUNT, any transition is taken as a mid-bit transition: it is decoded and strobed, the phase snaps to it, and the tracker enters TRAIN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling-domain clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Sample pair valid this cycle |
| smp_early | input | 1 | Earlier line sample of the pair |
| smp_late | input | 1 | Later line sample of the pair |
| rx_bit | output | 1 | Recovered bit, valid with `rx_stb` |
| rx_stb | output | 1 | One-cycle strobe per recovered bit |
| locked | output | 1 | Tracker is in LOCK |

## Verification
The bench goes after these corner cases:
- **Jitter**: mid-bit transitions are shifted one sample early and late in a random walk. A tracker that only counted, instead of re-aligning, would drift out of its window and drop bits.
- **Bit boundaries**: runs of equal bits put transitions at boundaries. A design that took these for data would emit extra strobes.
- **Lock timing**: held-level bit periods are placed during training and during lock, and the bench checks the exact strobe count at which lock rises and the exact sample pair at which it falls. Off-by-one counters show up as a shifted lock or drop point.
- **Enable gaps**: gaps are placed inside a live stream. A design that consumed samples while disabled would lose phase and mis-decode the bits that follow.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_LOCK  = 2'd2
    } trk_e;
endpackage

// File: rtl/mcr_win.sv
// Classifies the phase counter against the expected mid-bit window.
module mcr_win #(
    parameter int SPB = 8
) (
    input  logic [$clog2(SPB)-1:0] ph,
    output logic                   in_win,
    output logic                   at_last,
    output logic                   at_wrap
);
    localparam int PW  = $clog2(SPB);
    localparam int MID = SPB / 2;
    localparam logic [PW-1:0] LO   = PW'(MID - 1);
    localparam logic [PW-1:0] HI   = PW'(MID + 1);
    localparam logic [PW-1:0] WRAP = PW'(SPB - 1);

    assign in_win  = (ph >= LO) && (ph <= HI);
    assign at_last = (ph == HI);
    assign at_wrap = (ph == WRAP);
endmodule

// File: rtl/mcr_step.sv
// Advances the tracker by one line sample.
module mcr_step #(
    parameter int SPB        = 8,
    parameter int LOCK_BITS  = 16,
    parameter int MISS_LIMIT = 4
) (
    input  mcr_pkg::trk_e                           st_in,
    input  logic [$clog2(SPB)-1:0]                  ph_in,
    input  logic                                    got_in,
    input  logic [$clog2(LOCK_BITS+1)-1:0]          good_in,
    input  logic [$clog2(MISS_LIMIT+1)-1:0]         miss_in,
    input  logic                                    prev_in,
    input  logic                                    smp,
    output mcr_pkg::trk_e                           st_out,
    output logic [$clog2(SPB)-1:0]                  ph_out,
    output logic                                    got_out,
    output logic [$clog2(LOCK_BITS+1)-1:0]          good_out,
    output logic [$clog2(MISS_LIMIT+1)-1:0]         miss_out,
    output logic                                    prev_out,
    output logic                                    emit,
    output logic                                    ebit
);
    import mcr_pkg::*;

    localparam int PW = $clog2(SPB);
    localparam int GW = $clog2(LOCK_BITS + 1);
    localparam int MW = $clog2(MISS_LIMIT + 1);
    localparam logic [PW-1:0] SNAP = PW'(SPB / 2 + 1);

    logic in_win, at_last, at_wrap;
    logic edge_seen, hit, lost;

    mcr_win #(.SPB(SPB)) win_i (
        .ph      (ph_in),
        .in_win  (in_win),
        .at_last (at_last),
        .at_wrap (at_wrap)
    );

    assign edge_seen = smp ^ prev_in;
    assign hit       = edge_seen && in_win && !got_in;
    assign lost      = at_last && !edge_seen && !got_in;
    assign prev_out  = smp;
    assign ebit      = smp;

    always_comb begin
        st_out   = st_in;
        ph_out   = at_wrap ? '0 : ph_in + 1'b1;
        got_out  = at_wrap ? 1'b0 : got_in;
        good_out = good_in;
        miss_out = miss_in;
        emit     = 1'b0;
        unique case (st_in)
            ST_HUNT: begin
                if (edge_seen) begin
                    st_out   = ST_TRAIN;
                    ph_out   = SNAP;
                    got_out  = 1'b1;
                    good_out = GW'(1);
                    miss_out = '0;
                    emit     = 1'b1;
                end
            end
            ST_TRAIN: begin
                if (hit) begin
                    ph_out   = SNAP;
                    got_out  = 1'b1;
                    emit     = 1'b1;
                    good_out = good_in + 1'b1;
                    if (good_in == GW'(LOCK_BITS - 1)) begin
                        st_out   = ST_LOCK;
                        miss_out = '0;
                    end
                end else if (lost) begin
                    st_out   = ST_HUNT;
                    good_out = '0;
                end
            end
            ST_LOCK: begin
                if (hit) begin
                    ph_out   = SNAP;
                    got_out  = 1'b1;
                    emit     = 1'b1;
                    miss_out = '0;
                end else if (lost) begin
                    if (miss_in == MW'(MISS_LIMIT - 1)) begin
                        st_out   = ST_HUNT;
                        miss_out = '0;
                        good_out = '0;
                    end else begin
                        miss_out = miss_in + 1'b1;
                    end
                end
            end
            default: st_out = ST_HUNT;
        endcase
    end
endmodule

// File: rtl/manch_cdr_rx.sv
// Manchester receiver: two chained per-sample steps, one state register
// process and one output register process.
module manch_cdr_rx #(
    parameter int SPB        = 8,
    parameter int LOCK_BITS  = 16,
    parameter int MISS_LIMIT = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic smp_early,
    input  logic smp_late,
    output logic rx_bit,
    output logic rx_stb,
    output logic locked
);
    import mcr_pkg::*;

    localparam int PW    = $clog2(SPB);
    localparam int GW    = $clog2(LOCK_BITS + 1);
    localparam int MW    = $clog2(MISS_LIMIT + 1);
    localparam int NSMP  = 2;

    trk_e           st_q;
    logic [PW-1:0]  ph_q;
    logic           got_q;
    logic [GW-1:0]  good_q;
    logic [MW-1:0]  miss_q;
    logic           prev_q;

    trk_e           st_c   [NSMP+1];
    logic [PW-1:0]  ph_c   [NSMP+1];
    logic           got_c  [NSMP+1];
    logic [GW-1:0]  good_c [NSMP+1];
    logic [MW-1:0]  miss_c [NSMP+1];
    logic           prev_c [NSMP+1];
    logic           emit_c [NSMP];
    logic           ebit_c [NSMP];
    logic [NSMP-1:0] smp_w;

    assign smp_w     = {smp_late, smp_early};
    assign st_c[0]   = st_q;
    assign ph_c[0]   = ph_q;
    assign got_c[0]  = got_q;
    assign good_c[0] = good_q;
    assign miss_c[0] = miss_q;
    assign prev_c[0] = prev_q;

    for (genvar k = 0; k < NSMP; k++) begin : g_step
        mcr_step #(
            .SPB        (SPB),
            .LOCK_BITS  (LOCK_BITS),
            .MISS_LIMIT (MISS_LIMIT)
        ) step_i (
            .st_in    (st_c[k]),
            .ph_in    (ph_c[k]),
            .got_in   (got_c[k]),
            .good_in  (good_c[k]),
            .miss_in  (miss_c[k]),
            .prev_in  (prev_c[k]),
            .smp      (smp_w[k]),
            .st_out   (st_c[k+1]),
            .ph_out   (ph_c[k+1]),
            .got_out  (got_c[k+1]),
            .good_out (good_c[k+1]),
            .miss_out (miss_c[k+1]),
            .prev_out (prev_c[k+1]),
            .emit     (emit_c[k]),
            .ebit     (ebit_c[k])
        );
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            ph_q   <= '0;
            got_q  <= 1'b0;
            good_q <= '0;
            miss_q <= '0;
            prev_q <= 1'b0;
        end else if (en) begin
            st_q   <= st_c[NSMP];
            ph_q   <= ph_c[NSMP];
            got_q  <= got_c[NSMP];
            good_q <= good_c[NSMP];
            miss_q <= miss_c[NSMP];
            prev_q <= prev_c[NSMP];
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_stb <= 1'b0;
            rx_bit <= 1'b0;
            locked <= 1'b0;
        end else if (en) begin
            rx_stb <= emit_c[0] | emit_c[1];
            if (emit_c[0]) begin
                rx_bit <= ebit_c[0];
            end else if (emit_c[1]) begin
                rx_bit <= ebit_c[1];
            end
            locked <= (st_c[NSMP] == ST_LOCK);
        end else begin
            rx_stb <= 1'b0;
        end
    end
endmodule

// File: rtl/mcr_chk.sv
module mcr_chk (
    input logic clk,
    input logic rst,
    input logic en,
    input logic rx_stb,
    input logic locked
);
    // R1
    rst_clears_chk: assert property (@(posedge clk)
        rst |=> (!rx_stb && !locked));

    // R9
    idle_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !rx_stb);

    // R9
    idle_lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(locked));

    // R5
    lock_with_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> rx_stb);

    // R2
    single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        rx_stb |=> !rx_stb);

    // R7
    drop_no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> !rx_stb);
endmodule

bind manch_cdr_rx mcr_chk chk_i (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .rx_stb (rx_stb),
    .locked (locked)
);

// File: tb/manch_cdr_rx_tb_top.sv
`timescale 1ns/1ps
module manch_cdr_rx_tb_top;
    localparam int SPB       = 8;
    localparam int LOCK_BITS = 16;
    localparam int HALF      = SPB / 2;
    localparam int WDOG      = 100000;

    logic clk = 1'b0;
    logic rst, en, smp_early, smp_late;
    logic rx_bit, rx_stb, locked;

    always #2 clk = ~clk;

    manch_cdr_rx #(.SPB(SPB), .LOCK_BITS(LOCK_BITS), .MISS_LIMIT(4)) dut_i (
        .clk (clk), .rst (rst), .en (en),
        .smp_early (smp_early), .smp_late (smp_late),
        .rx_bit (rx_bit), .rx_stb (rx_stb), .locked (locked)
    );

    int checks = 0, errors = 0;
    bit done = 1'b0;
    bit sbuf [$];
    bit exp_bit_q [$];
    int exp_mid_q [$];
    int pos = 0, prev_base = 0, n_stb = 0;
    int exp_lock_n = LOCK_BITS, exp_drop_base = -1, last_added_mid = 0;
    int cur_shift = 0;
    bit prev_en = 1'b0, lk_prev = 1'b0, line = 1'b0;

    // R2 encoding: first half inverted, second half equals the bit
    function automatic bit half_level(bit b, bit second);
        return second ? b : ~b;
    endfunction

    // R8: drop on the pair holding sample mid + 4*SPB + 1
    function automatic int drop_pair(int mid);
        return (mid + 4 * SPB + 1) & ~1;
    endfunction

    function automatic int walk(int s);
        int n = s + int'($urandom_range(0, 2)) - 1;
        if (n > 1) n = 1;
        if (n < -1) n = -1;
        return n;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic add_bit(bit b, int sh);
        int base = pos + sbuf.size();
        for (int i = 0; i < HALF + sh; i++) sbuf.push_back(half_level(b, 1'b0));
        for (int i = 0; i < HALF - sh; i++) sbuf.push_back(half_level(b, 1'b1));
        exp_bit_q.push_back(b);
        exp_mid_q.push_back(base + HALF + sh);
        last_added_mid = base + HALF + sh;
        line = b;
    endtask

    task automatic add_hold(int n);
        for (int i = 0; i < n; i++) sbuf.push_back(line);
    endtask

    task automatic observe();
        if (rx_stb) begin
            if (!prev_en) chk(1'b0, "R9 strobe after idle cycle", 1, 0);
            else if (exp_bit_q.size() == 0) chk(1'b0, "R3 spurious strobe", 1, 0);
            else begin
                bit b = exp_bit_q.pop_front();
                int m = exp_mid_q.pop_front();
                chk(rx_bit == b, "R2 bit value", int'(rx_bit), int'(b));
                chk((m >> 1) == (prev_base >> 1), "R2 strobe cycle", prev_base, m & ~1);
                n_stb++;
            end
        end
        if (locked && !lk_prev) begin
            chk(rx_stb, "R5 lock rises with strobe", int'(rx_stb), 1);
            chk(n_stb == exp_lock_n, "R5/R6 lock point", n_stb, exp_lock_n);
        end
        if (!locked && lk_prev)
            chk(exp_drop_base >= 0 && prev_base == exp_drop_base, "R7/R8 lock drop",
                prev_base, exp_drop_base);
        if (!prev_en) chk(locked == lk_prev, "R9 lock held", int'(locked), int'(lk_prev));
        lk_prev = locked;
    endtask

    task automatic step(bit want_en);
        @(negedge clk);
        observe();
        if (want_en && sbuf.size() >= 2) begin
            en = 1'b1;
            smp_early = sbuf.pop_front();
            smp_late  = sbuf.pop_front();
            prev_base = pos;
            pos += 2;
            prev_en = 1'b1;
        end else begin
            en = 1'b0;
            smp_early = 1'($urandom_range(0, 1));
            smp_late  = 1'($urandom_range(0, 1));
            prev_en = 1'b0;
        end
    endtask

    task automatic drain(int gap_pct);
        while (sbuf.size() >= 2) begin
            if (gap_pct > 0 && int'($urandom_range(0, 99)) < gap_pct) step(1'b0);
            else step(1'b1);
        end
        step(1'b0);
    endtask

    task automatic do_reset();
        @(negedge clk);
        observe();
        rst = 1'b1; en = 1'b0; smp_early = 1'b0; smp_late = 1'b0; prev_en = 1'b0;
        @(negedge clk);
        chk(!rx_stb && !locked, "R1 reset state", int'({rx_stb, locked}), 0);
        @(negedge clk);
        rst = 1'b0;
        lk_prev = 1'b0; line = 1'b0;
        sbuf.delete(); exp_bit_q.delete(); exp_mid_q.delete();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        bit pat [20] = '{1,0,1,1,1,0,0,0,1,1,0,1,0,0,1,0,1,1,0,0};
        int dsh [10] = '{1,0,-1,0,1,1,0,-1,-1,0};
        void'($urandom(32'h5A17_C0DE));
        rst = 1'b1; en = 1'b0; smp_early = 1'b0; smp_late = 1'b0;
        repeat (3) @(negedge clk);
        chk(!rx_stb && !locked, "R1 state after reset", int'({rx_stb, locked}), 0);
        rst = 1'b0;

        // Idle line: nothing to decode (R10 waits in HUNT)
        add_hold(16);
        drain(0);

        // R2 R3 R5 R10: fixed pattern with boundary transitions
        exp_lock_n = LOCK_BITS;
        foreach (pat[i]) add_bit(pat[i], 0);
        drain(0);
        chk(locked, "R5 locked after pattern", int'(locked), 1);
        chk(n_stb == 20, "R2 strobe count", n_stb, 20);

        // R4: early/late mid-bit transitions
        foreach (dsh[i]) add_bit(1'($urandom_range(0, 1)), dsh[i]);
        cur_shift = 0;
        for (int i = 0; i < 40; i++) begin
            cur_shift = walk(cur_shift);
            add_bit(1'($urandom_range(0, 1)), cur_shift);
        end
        drain(0);
        chk(locked, "R4 lock held under jitter", int'(locked), 1);
        chk(exp_bit_q.size() == 0, "R4 all bits decoded", exp_bit_q.size(), 0);

        // R7: up to three misses keep lock, a good bit clears the count
        add_hold(3 * SPB);
        for (int i = 0; i < 5; i++) add_bit(1'($urandom_range(0, 1)), 0);
        add_hold(3 * SPB);
        for (int i = 0; i < 5; i++) add_bit(1'($urandom_range(0, 1)), 0);
        drain(0);
        chk(locked, "R7 three misses keep lock", int'(locked), 1);
        chk(exp_bit_q.size() == 0, "R7 good bits decoded", exp_bit_q.size(), 0);

        // R9: enable gaps inside a live stream
        for (int i = 0; i < 24; i++) add_bit(1'($urandom_range(0, 1)), 0);
        drain(35);
        chk(locked, "R9 lock after gaps", int'(locked), 1);
        chk(exp_bit_q.size() == 0, "R9 bits after gaps", exp_bit_q.size(), 0);

        // R8: fourth miss drops lock at a fixed sample
        exp_drop_base = drop_pair(last_added_mid);
        add_hold(6 * SPB);
        drain(0);
        chk(!locked, "R8 lock dropped", int'(locked), 0);
        exp_drop_base = -1;

        // R6 R10: reacquire, miss during training restarts the count
        exp_lock_n = n_stb + 10 + LOCK_BITS;
        add_bit(~line, 0);
        for (int i = 1; i < 10; i++) add_bit(1'($urandom_range(0, 1)), 0);
        add_hold(SPB);
        add_bit(~line, 0);
        for (int i = 0; i < 19; i++) add_bit(1'($urandom_range(0, 1)), 0);
        drain(0);
        chk(locked, "R6 relock after training miss", int'(locked), 1);

        // R1: reset in the middle of a stream, then reacquire
        for (int i = 0; i < 4; i++) add_bit(1'($urandom_range(0, 1)), 0);
        drain(0);
        do_reset();
        exp_lock_n = n_stb + LOCK_BITS;
        add_hold(6);
        add_bit(1'b1, 0);
        for (int i = 0; i < 17; i++) add_bit(1'($urandom_range(0, 1)), 0);
        add_hold(2);
        drain(0);
        chk(locked, "R1 relock after reset", int'(locked), 1);
        chk(exp_bit_q.size() == 0, "R1 bits after reset", exp_bit_q.size(), 0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", WDOG, 0);
            summary();
            $finish;
        end
    end
endmodule